// File: doc/BRIEF.md
# Full-Duplex Serial Front End for a Multi-Channel Converter

This block is the digital side of a multi-channel analog-to-digital converter. It works as a four-wire synchronous serial slave: chip select (active low), shift clock, data in and data out. Each chip-select frame does two things at once. It receives an 8-bit setup word for the next conversion, and it sends out the 12-bit result of the conversion requested in the frame before. The setup word picks the input channel and the coding polarity. It also picks how the next result is sent: the bit order, and a length of 8, 12 or 16 bits.

The serial pins are not tied to the system clock. They pass through two-flop synchronizers and their edges are detected in the system clock domain, so the shift clock must run at no more than one quarter of the system clock rate. When a frame closes with a complete setup word, the block presents the new channel and polarity and pulses a conversion-start strobe. It then holds a busy flag for a fixed number of system clocks. When that count runs out, it takes the 12-bit value on its converter result port. That value is what the next frame shifts out.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset, dout_en, dout, conv_busy, mux_sel and unipolar are all 0, and the first frame shifts out only zeros.
- R2: The setup word is sampled from din on the first eight rising shift-clock edges of a frame. The first bit goes to mux_sel[3] (single-ended/differential), then mux_sel[2] (odd/sign), mux_sel[1], mux_sel[0], unipolar, the bit-order bit (1 = most significant first) and the two length bits (high one first).
- R3: din is ignored after the eighth rising shift-clock edge, until the next frame.
- R4: A frame that closes after at least eight setup bits produces exactly one conv_start pulse. mux_sel and unipolar take the new values in that same cycle and change at no other time. conv_busy is then high for exactly CONV_CYCLES system clocks.
- R5: A frame that closes with fewer than eight setup bits is discarded. There is no conv_start, mux_sel and unipolar keep their values, and the next frame shifts out the same result as this one.
- R6: The frame after the one that requested a conversion shifts out the value that conv_result held in the last busy cycle.
- R7: The length bits set the output word W and its length L. 00 gives the top 8 result bits (L=8). 01 and 10 give the full 12 bits (L=12). 11 gives the 12 bits followed by four zero bits (L=16). Bit positions L and beyond of a frame are 0.
- R8: With the bit-order bit at 1, W[L-1] goes out first. With it at 0, W[0] goes out first. The first bit is on dout before the first rising shift-clock edge, and each later bit follows a falling shift-clock edge.
- R9: Outside a frame, dout_en and dout are 0. Inside a frame, dout_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial shift clock, idles low |
| din | input | 1 | Serial setup word in |
| dout | output | 1 | Serial result out |
| dout_en | output | 1 | High while a frame is open |
| conv_start | output | 1 | One-cycle conversion request |
| conv_busy | output | 1 | High during the conversion latency |
| mux_sel | output | 4 | Channel address of the current conversion |
| unipolar | output | 1 | Coding polarity of the current conversion |
| conv_result | input | 12 | Result from the converter core |

## Verification
The bench sends all 256 setup words in back-to-back frames. Each frame clocks 16 bits, so all eight combinations of bit order and length are exercised. The zero fill past an 8-bit or 12-bit word is checked too, against the result requested one frame earlier. A converter stub mixes the channel, the polarity and a per-frame seed, so a result taken from the wrong frame or the wrong channel gives a different bit pattern. Random bits after the eighth bit show whether late din changes the setup word. A five-bit frame at the end, followed by a full frame, separates a discarded partial word from an accepted one.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
    localparam int RES_BITS   = 12;
    localparam int CFG_BITS   = 8;
    localparam int SHORT_LEN  = 8;
    localparam int MAX_FRAME  = 16;
    localparam int IDX_W      = $clog2(MAX_FRAME + 1);
    localparam int CNT_W      = $clog2(CFG_BITS + 1);
    localparam int MUX_BITS   = 4;

    typedef enum logic [1:0] {
        WL_SHORT  = 2'b00,
        WL_FULL_A = 2'b01,
        WL_FULL_B = 2'b10,
        WL_PAD    = 2'b11
    } wlen_e;

    typedef struct packed {
        logic  msb_first;
        wlen_e wlen;
    } fmt_t;

    // Bit of the outgoing word at serial position idx
    function automatic logic frame_bit(input logic [RES_BITS-1:0] res,
                                       input fmt_t f,
                                       input logic [IDX_W-1:0] idx);
        int len;
        int pos;
        logic [MAX_FRAME-1:0] w;
        logic [MAX_FRAME-1:0] sh;
        case (f.wlen)
            WL_SHORT: begin
                len = SHORT_LEN;
                w   = MAX_FRAME'(res >> (RES_BITS - SHORT_LEN));
            end
            WL_PAD: begin
                len = MAX_FRAME;
                w   = MAX_FRAME'(res) << (MAX_FRAME - RES_BITS);
            end
            default: begin
                len = RES_BITS;
                w   = MAX_FRAME'(res);
            end
        endcase
        if (int'(idx) >= len) return 1'b0;
        pos = f.msb_first ? (len - 1 - int'(idx)) : int'(idx);
        sh  = w >> pos;
        return sh[0];
    endfunction
endpackage

// File: rtl/adcs_sync.sv
module adcs_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/adcs_frame.sv
module adcs_frame
    import adcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_s,
    input  logic                sclk_s,
    input  logic                din_s,
    input  logic [RES_BITS-1:0] res,
    input  fmt_t                fmt,
    output logic                dout,
    output logic                dout_en,
    output logic                frame_done,
    output logic                cs_rise,
    output logic [CFG_BITS-1:0] cfg_word
);
    typedef struct packed {
        logic                cs_prev;
        logic                sclk_prev;
        logic                en;
        logic [CNT_W-1:0]    in_cnt;
        logic [CFG_BITS-1:0] cfg_sh;
        logic [IDX_W-1:0]    out_idx;
        logic                dout;
        logic                done;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic cs_fall, sclk_rise, sclk_fall;

    always_comb begin
        st_d           = st_q;
        st_d.cs_prev   = cs_s;
        st_d.sclk_prev = sclk_s;
        st_d.done      = 1'b0;
        cs_fall   = st_q.cs_prev & ~cs_s;
        cs_rise   = ~st_q.cs_prev & cs_s;
        sclk_rise = st_q.en & ~st_q.sclk_prev & sclk_s;
        sclk_fall = st_q.en & st_q.sclk_prev & ~sclk_s;
        if (cs_fall) begin
            st_d.en      = 1'b1;
            st_d.in_cnt  = '0;
            st_d.out_idx = '0;
            st_d.dout    = frame_bit(res, fmt, '0);
        end else if (cs_rise) begin
            st_d.en   = 1'b0;
            st_d.dout = 1'b0;
            st_d.done = st_q.en && (st_q.in_cnt == CNT_W'(CFG_BITS));
        end else if (st_q.en) begin
            if (sclk_rise && st_q.in_cnt < CNT_W'(CFG_BITS)) begin
                st_d.cfg_sh = {st_q.cfg_sh[CFG_BITS-2:0], din_s};
                st_d.in_cnt = st_q.in_cnt + 1'b1;
            end
            if (sclk_fall && st_q.out_idx < IDX_W'(MAX_FRAME)) begin
                st_d.out_idx = st_q.out_idx + 1'b1;
                st_d.dout    = frame_bit(res, fmt, IDX_W'(st_q.out_idx + 1'b1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cs_prev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout       = st_q.dout;
    assign dout_en    = st_q.en;
    assign frame_done = st_q.done;
    assign cfg_word   = st_q.cfg_sh;

    // R3
    cfg_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_cnt <= CNT_W'(CFG_BITS));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> !dout);
    // R3
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_cnt == CNT_W'(CFG_BITS) && !cs_fall) |=> $stable(st_q.cfg_sh));
endmodule

// File: rtl/adcs_conv.sv
module adcs_conv
    import adcs_pkg::*;
#(
    parameter int CONV_CYCLES = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  logic [CFG_BITS-1:0] cfg_word,
    input  logic [RES_BITS-1:0] conv_result,
    output logic                conv_start,
    output logic                conv_busy,
    output logic [MUX_BITS-1:0] mux_sel,
    output logic                unipolar,
    output logic [RES_BITS-1:0] res,
    output fmt_t                fmt
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0]       cnt;
        logic                start;
        logic [MUX_BITS-1:0] mux;
        logic                uni;
        fmt_t                pend;
        fmt_t                fmt;
        logic [RES_BITS-1:0] res;
    } conv_st_t;

    conv_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.res = conv_result;
                st_d.fmt = st_q.pend;
            end
        end
        if (frame_done) begin
            st_d.start = 1'b1;
            st_d.cnt   = CW'(CONV_CYCLES);
            st_d.mux   = cfg_word[CFG_BITS-1 -: MUX_BITS];
            st_d.uni   = cfg_word[3];
            st_d.pend  = fmt_t'(cfg_word[2:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_start = st_q.start;
    assign conv_busy  = (st_q.cnt != '0);
    assign mux_sel    = st_q.mux;
    assign unipolar   = st_q.uni;
    assign res        = st_q.res;
    assign fmt        = st_q.fmt;

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_busy);
    // R4
    busy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(CONV_CYCLES));
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
    import adcs_pkg::*;
#(
    parameter int CONV_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                din,
    output logic                dout,
    output logic                dout_en,
    output logic                conv_start,
    output logic                conv_busy,
    output logic [MUX_BITS-1:0] mux_sel,
    output logic                unipolar,
    input  logic [RES_BITS-1:0] conv_result
);
    logic [2:0]          pins_s;
    logic                frame_done, cs_rise;
    logic [CFG_BITS-1:0] cfg_word;
    logic [RES_BITS-1:0] res;
    fmt_t                fmt;

    adcs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, din}),
        .q     (pins_s)
    );

    adcs_frame i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (pins_s[2]),
        .sclk_s     (pins_s[1]),
        .din_s      (pins_s[0]),
        .res        (res),
        .fmt        (fmt),
        .dout       (dout),
        .dout_en    (dout_en),
        .frame_done (frame_done),
        .cs_rise    (cs_rise),
        .cfg_word   (cfg_word)
    );

    adcs_conv #(.CONV_CYCLES(CONV_CYCLES)) i_conv (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .cfg_word    (cfg_word),
        .conv_result (conv_result),
        .conv_start  (conv_start),
        .conv_busy   (conv_busy),
        .mux_sel     (mux_sel),
        .unipolar    (unipolar),
        .res         (res),
        .fmt         (fmt)
    );

    // R5
    start_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(frame_done));
    // R5
    done_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(cs_rise));
    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> ($stable(mux_sel) && $stable(unipolar)));
endmodule

// File: tb/test_adc_serial_ctrl.sv
module test_adc_serial_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CONV       = 20;
    localparam int HALF       = 8;
    localparam int TAIL       = CONV + 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic dout, dout_en, conv_start, conv_busy, unipolar;
    logic [3:0]  mux_sel;
    logic [11:0] conv_result;

    int vectors = 0;
    int fails   = 0;
    int seed    = 0;
    int starts  = 0;
    int run     = 0;
    int last_run = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_ctrl #(.CONV_CYCLES(CONV)) i_adc_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_en(dout_en), .conv_start(conv_start),
        .conv_busy(conv_busy), .mux_sel(mux_sel), .unipolar(unipolar),
        .conv_result(conv_result)
    );

    function automatic int stub_val(int s, int ch, int u);
        return (s * 1103 + ch * 97 + u * 2048 + 5) % 4096;
    endfunction

    always_comb conv_result = 12'(stub_val(seed, int'(mux_sel), int'(unipolar)));

    always @(posedge clk) begin
        if (conv_start) starts++;
        if (conv_busy) run++;
        else if (run != 0) begin last_run = run; run = 0; end
    end

    function automatic logic exp_bit(int r, bit msbf, int wl, int i);
        int len; int w;
        if (wl == 0) begin len = 8; w = r / 16; end
        else if (wl == 3) begin len = 16; w = r * 16; end
        else begin len = 12; w = r; end
        if (i >= len) return 1'b0;
        if (msbf) return 1'(w >> (len - 1 - i));
        return 1'(w >> i);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic run_frame(input logic [7:0] cfg, input int nclk, output logic [15:0] got);
        got = '0;
        step(1);
        cs_n = 1'b0;
        for (int i = 0; i < nclk; i++) begin
            din = (i < 8) ? cfg[7-i] : 1'($urandom);
            step(HALF);
            got[i] = dout;
            if (i == 0) chk(dout_en === 1'b1, "R9 dout_en in frame", int'(dout_en), 1);
            sclk = 1'b1;
            step(HALF);
            sclk = 1'b0;
        end
        step(HALF);
        cs_n = 1'b1;
        step(TAIL);
    endtask

    int  e_res = 0;
    bit  e_msbf = 0;
    int  e_wl = 0;

    task automatic check_bits(input logic [15:0] got, input int n, input string tag);
        for (int i = 0; i < n; i++)
            chk(got[i] === exp_bit(e_res, e_msbf, e_wl, i), tag, int'(got[i]),
                int'(exp_bit(e_res, e_msbf, e_wl, i)));
    endtask

    initial begin
        logic [15:0] got;
        logic [3:0]  mux_before;
        logic        uni_before;
        int          st_before;
        step(5);
        // R1 reset state
        chk(dout_en === 1'b0 && dout === 1'b0, "R1 serial out idle", int'({dout_en, dout}), 0);
        chk(conv_busy === 1'b0, "R1 busy low", int'(conv_busy), 0);
        chk(mux_sel === 4'd0 && unipolar === 1'b0, "R1 config zero", int'({mux_sel, unipolar}), 0);
        rst_n = 1'b1;
        step(5);
        // Sweep every setup word, plus one trailing frame to read the last result
        for (int c = 0; c <= 256; c++) begin
            logic [7:0] cfg;
            cfg = 8'(c % 256);
            seed++;
            // R9 idle before frame
            chk(dout_en === 1'b0 && dout === 1'b0, "R9 idle between frames", int'({dout_en, dout}), 0);
            st_before = starts;
            last_run = 0;
            run_frame(cfg, 16, got);
            // R6 R7 R8: bits are the previous frame's result in its requested format
            check_bits(got, 16, (c == 0) ? "R1 first frame zeros" : "R6 R7 R8 result bits");
            // R2 decoded setup
            chk(mux_sel === cfg[7:4], "R2 mux_sel", int'(mux_sel), int'(cfg[7:4]));
            chk(unipolar === cfg[3], "R2 unipolar", int'(unipolar), int'(cfg[3]));
            // R4 one start, busy length
            chk(starts == st_before + 1, "R4 start count", starts - st_before, 1);
            chk(last_run == CONV, "R4 busy length", last_run, CONV);
            // R3: junk after bit 8 must not matter; covered by R2 check above
            e_res  = stub_val(seed, int'(cfg[7:4]), int'(cfg[3]));
            e_msbf = cfg[2];
            e_wl   = int'(cfg[1:0]);
        end
        // R5 short frame discarded
        mux_before = mux_sel;
        uni_before = unipolar;
        st_before  = starts;
        seed++;
        run_frame(8'hFF, 5, got);
        check_bits(got, 5, "R5 short frame bits");
        chk(starts == st_before, "R5 no start", starts - st_before, 0);
        chk(mux_sel === mux_before && unipolar === uni_before, "R5 config kept",
            int'({mux_sel, unipolar}), int'({mux_before, uni_before}));
        seed++;
        run_frame(8'h5A, 16, got);
        check_bits(got, 16, "R5 result repeated after short frame");
        chk(mux_sel === 4'h5, "R2 mux after recovery", int'(mux_sel), 5);
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog: got %0h expected %0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule